// File: doc/BRIEF.md
# Ping-Pong LIFO Block Reverser

This stage sits between the fold multiplexer and the reverse delay line of a decimating symmetric filter. In a decimating filter the samples sent back along the reverse path must arrive in reversed order for each block of N samples, so that matching taps line up at the adders. The stage holds two LIFO buffers. One fills from the forward path while the other empties, last sample first, into the reverse path.

A transfer strobe marks block boundaries. When it goes from high to low, the two buffers swap roles. For decimation by N, the strobe is pulsed low once every N clocks. Each block of N samples then leaves the stage reversed, one block later. When reversal is switched off, as it must be for interleaved data, the stage is a plain one-clock register.

Top module: `lifo_reverser`

## Requirements
- R1: While `rst_n` is low, `dout` is zero, both LIFOs are emptied, and the stored strobe history is low. A strobe that is held low when reset is released therefore causes no swap.
- R2: With `rev_en` low, `dout` equals the `din` sampled at the previous clock edge. Both LIFOs are emptied, so after reversal is re-enabled the output is zero until the first swap.
- R3: With `rev_en` high, on each clock edge that is not a swap, `din` is pushed onto the receiving LIFO.
- R4: A swap happens on the clock edge where `xfer` is sampled low after it was sampled high on the previous edge. At that edge the receiving and sending LIFOs exchange roles. The `din` sampled at that edge becomes the first entry of the new receiving LIFO.
- R5: A strobe that stays low, or stays high, over several edges causes no further swap.
- R6: A block of samples pushed between two swaps leaves on `dout` in reverse order. The last sample appears at the edge of the closing swap, and one earlier sample follows on each later edge.
- R7: On an edge where the sending LIFO is empty, `dout` becomes zero.
- R8: Once a block holds DEPTH samples, further samples in that block are dropped. The first DEPTH samples are kept.
- R9: At a swap, any entries not yet read from the sending LIFO are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rev_en | input | 1 | 1 = reversal enabled, 0 = one-clock register |
| xfer | input | 1 | Transfer strobe; a high-to-low transition swaps the LIFOs |
| din | input | W | Sample from the fold multiplexer |
| dout | output | W | Sample to the reverse path |

## Verification
Wrong internal state shows up in one of three ways. A bad write count shows as lost or duplicated samples when the next block drains. A bad read count shows as a wrong value or a missing zero within one clock of the swap. A bad role select shows as a whole block of stale data. A model built from queues predicts `dout` on every clock, so each fault is caught at the first edge where the output differs. The stimulus covers several block lengths, a strobe held low, blocks longer than DEPTH, blocks that are cut short, and switching between the two modes.

// File: rtl/lifo_reverser.sv
module lifo_reverser #(
  parameter int W     = 16,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rev_en,
  input  logic         xfer,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [2][DEPTH];
  logic          sel;
  logic          xfer_q;
  logic [CW-1:0] wcnt, rcnt;

  wire           fall    = xfer_q & ~xfer;
  wire           src_sel = fall ? sel : ~sel;
  wire [CW-1:0]  src_cnt = fall ? wcnt : rcnt;
  wire [CW-1:0]  pidx    = src_cnt - 1'b1;
  wire [W-1:0]   pop     = mem[src_sel][pidx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rev_en) begin
      if (fall)
        mem[~sel][0] <= din;
      else if (wcnt != FULL)
        mem[sel][wcnt[AW-1:0]] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel    <= 1'b0;
      xfer_q <= 1'b0;
      wcnt   <= '0;
      rcnt   <= '0;
      dout   <= '0;
    end else begin
      xfer_q <= xfer;
      if (!rev_en) begin
        wcnt <= '0;
        rcnt <= '0;
        dout <= din;
      end else begin
        if (fall) begin
          sel  <= ~sel;
          wcnt <= CW'(1);
        end else if (wcnt != FULL) begin
          wcnt <= wcnt + 1'b1;
        end
        if (src_cnt != '0) begin
          dout <= pop;
          rcnt <= pidx;
        end else begin
          dout <= '0;
          rcnt <= '0;
        end
      end
    end
  end

  AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    !rev_en |=> dout == $past(din));                                   // R2
  AST_SWAP_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_en && xfer_q && !xfer) |=> sel != $past(sel));                // R4
  AST_NO_SWAP_ELSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_q && !xfer) |=> $stable(sel));                              // R5
  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rev_en && src_cnt == '0) |=> dout == '0);                         // R7
  AST_WCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= FULL);                                                     // R8
  AST_RCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= FULL);                                                     // R9
endmodule

// File: tb/lifo_reverser_tb_top.sv
`timescale 1ns/100ps
module lifo_reverser_tb_top;
  localparam int W = 16;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rev_en = 1'b0;
  logic xfer = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;

  int total = 0;
  int bad = 0;
  int ctr = 1;
  bit done = 0;

  logic [W-1:0] fillq[$];
  logic [W-1:0] drainq[$];
  logic         xq = 1'b0;

  always #2.5 clk = ~clk;

  lifo_reverser #(.W(W), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .rev_en(rev_en), .xfer(xfer), .din(din), .dout(dout));

  task automatic check(input logic [W-1:0] exp, input string tag);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s: dout=%0h expected=%0h", tag, dout, exp);
    end
  endtask

  task automatic step(input logic [W-1:0] d, input logic en, input logic xf, input string tag);
    logic [W-1:0] exp;
    string t;
    t = tag;
    rev_en = en; xfer = xf; din = d;
    if (!en) begin
      exp = d;
      fillq.delete();
      drainq.delete();
    end else begin
      if (xq && !xf) begin
        drainq = fillq;
        fillq.delete();
        fillq.push_back(d);
        t = {tag, "/R4"};
      end else if (fillq.size() < DEPTH) begin
        fillq.push_back(d);
      end
      if (drainq.size() > 0) exp = drainq.pop_back();
      else begin exp = '0; t = {t, "/R7"}; end
    end
    xq = xf;
    @(negedge clk);
    check(exp, t);
  endtask

  task automatic run_block(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(W'(ctr), 1'b1, (i == 0) ? 1'b0 : 1'b1, tag);
      ctr++;
    end
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: expired expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check('0, "R1");
    rst_n = 1'b1;
    // R1: strobe held low out of reset, no swap
    for (int i = 0; i < 3; i++) step(W'(16'h1000 + i), 1'b1, 1'b0, "R1");
    for (int i = 0; i < 20; i++) step(W'($urandom), 1'b0, W'(i) % 2 == 0, "R2");
    run_block(5, "R3");
    run_block(4, "R6");
    repeat (5) run_block(4, "R6");
    repeat (4) run_block(7, "R6");
    repeat (4) run_block(2, "R6");
    repeat (3) run_block(DEPTH, "R6");
    // R5: strobe held low, then held high
    for (int i = 0; i < 8; i++) begin step(W'(ctr), 1'b1, 1'b0, "R5"); ctr++; end
    for (int i = 0; i < 8; i++) begin step(W'(ctr), 1'b1, 1'b1, "R5"); ctr++; end
    repeat (3) run_block(DEPTH + 5, "R8");
    run_block(9, "R9");
    run_block(3, "R9");
    run_block(6, "R9");
    run_block(2, "R9");
    run_block(5, "R9");
    for (int i = 0; i < 10; i++) step(W'(ctr + i), 1'b0, 1'b1, "R2");
    repeat (2) run_block(5, "R2");
    for (int i = 0; i < 5; i++) step(W'(ctr + i), 1'b1, 1'b1, "R6");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule